// File: doc/BRIEF.md
# Serial Four-Channel DAC Register Front End

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter that is programmed over a three-wire serial port: an active-low select, a serial clock and a data line. Every pin is sampled by a faster system clock through two-flop synchronizers. The block finds rising edges of the serial clock itself and shifts data in, most significant bit first, while the select is low.

When the select is released after exactly twelve serial clocks, the captured word goes into the input register of the channel that the word addresses. Any other bit count throws the frame away. An active-low load strobe copies every input register into its DAC register. The copy is level-transparent, so while the strobe stays low the DAC registers keep following the input registers. An active-low clear zeroes all input and DAC registers and leaves the shift register alone. A shutdown input is passed through to a shutdown flag and changes no register.

The frame is handled by a four-state machine. `FS_IDLE` waits with the select high. The select going low takes the begin transition to `FS_SHIFT`, which also zeroes the bit counter. In `FS_SHIFT`, a select release with a count of twelve takes the accept transition to `FS_COMMIT`, and a release with any other count takes the reject transition to `FS_DROP`. `FS_COMMIT` raises the write for one cycle and returns to `FS_IDLE`. `FS_DROP` returns to `FS_IDLE` without a write.

Top module: `quad_dac_serial_front`

## Requirements
- R1: A frame is 12 bits, shifted in on the rising serial clock, first bit first. The bits are 2 address bits (00 = channel A in `dac_code_o[7:0]`, 01 = B in `[15:8]`, 10 = C in `[23:16]`, 11 = D in `[31:24]`), then 2 reserved bits whose value is ignored, then 8 data bits, MSB first.
- R2: While the select is high, serial clock edges shift nothing and change no register.
- R3: A select release after exactly 12 serial clocks writes the data byte into the addressed channel's input register only. The other three input registers keep their values.
- R4: While the load strobe is low, every DAC register follows its input register, including writes that land while the strobe is held low.
- R5: While the load strobe is high, the DAC registers hold. A new write does not reach `dac_code_o` until the next load.
- R6: While the clear input is low, all input and DAC registers are zero, and writes and loads have no effect.
- R7: A select release after any count other than 12 changes no input register.
- R8: Clear does not disturb the shift register, so a frame that spans a clear pulse still delivers all 12 of its bits.
- R9: `shdn_o` follows `shdn_i` after synchronization. Shutdown changes no register contents, and writes and loads keep working while it is active.
- R10: After system reset, all four DAC codes are zero and `shdn_o` is 0.
- R11: The load strobe works regardless of the select, including in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low system reset |
| cs_n_i | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data |
| load_n_i | input | 1 | Load strobe, active low, level-transparent |
| clear_n_i | input | 1 | Clear, active low |
| shdn_i | input | 1 | Shutdown request |
| dac_code_o | output | NUM_CH*DATA_W | DAC register values, channel A in the low byte |
| shdn_o | output | 1 | Synchronized shutdown flag |

## Verification
A wrong bit count or a stuck state in the frame machine shows up at the ports as a frame that is lost, or written to the wrong channel, or a bad-count frame that gets through. Each of these appears at `dac_code_o` once the next load reaches the port, about a dozen system clocks after the select rises. A wrong input register stays hidden behind the held DAC register until a load. For that reason the bench follows every write with a load, or keeps the strobe low, before it compares all four channels. A clear or load that takes the wrong priority shows up within a few cycles of the synchronizer delay.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_SHIFT  = 2'd1,
        FS_COMMIT = 2'd2,
        FS_DROP   = 2'd3
    } frame_state_e;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dacfe_frame_fsm.sv
module dacfe_frame_fsm
    import dacfe_pkg::*;
#(
    parameter int FRAME_BITS = 12,
    parameter int CNT_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_s,
    input  logic                  sclk_rise,
    input  logic                  sdi_s,
    output frame_state_e          st,
    output logic [CNT_W-1:0]      bit_cnt,
    output logic [FRAME_BITS-1:0] shreg,
    output logic                  wr_en
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = '1;

    frame_state_e st_nx;

    // next-state decode
    always_comb begin
        st_nx = st;
        unique case (st)
            FS_IDLE:   if (!cs_s) st_nx = FS_SHIFT;
            FS_SHIFT:  if (cs_s)  st_nx = (bit_cnt == CNT_FULL) ? FS_COMMIT : FS_DROP;
            FS_COMMIT: st_nx = FS_IDLE;
            FS_DROP:   st_nx = FS_IDLE;
            default:   st_nx = FS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FS_IDLE;
        else        st <= st_nx;
    end

    // shift path and bit counter; only system reset touches them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (st == FS_IDLE && !cs_s) begin
            bit_cnt <= '0;
        end else if (st == FS_SHIFT && !cs_s && sclk_rise) begin
            shreg <= {shreg[FRAME_BITS-2:0], sdi_s};
            if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        wr_en = 1'b0;
        unique case (st)
            FS_COMMIT: wr_en = 1'b1;
            default:   wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/dacfe_reg_bank.sv
module dacfe_reg_bank #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_s,
    input  logic                     load_s,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [NUM_CH*DATA_W-1:0] in_flat,
    output logic [NUM_CH*DATA_W-1:0] dac_flat
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [DATA_W-1:0] in_q;
        logic [DATA_W-1:0] dac_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_q  <= '0;
                dac_q <= '0;
            end else if (!clr_s) begin
                in_q  <= '0;
                dac_q <= '0;
            end else begin
                if (wr_en && wr_addr == ADDR_W'(c)) in_q <= wr_data;
                if (!load_s) dac_q <= in_q;
            end
        end

        assign in_flat[c*DATA_W +: DATA_W]  = in_q;
        assign dac_flat[c*DATA_W +: DATA_W] = dac_q;
    end
endmodule

// File: rtl/quad_dac_serial_front.sv
module quad_dac_serial_front
    import dacfe_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int RSV_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n_i,
    input  logic                     sclk_i,
    input  logic                     sdi_i,
    input  logic                     load_n_i,
    input  logic                     clear_n_i,
    input  logic                     shdn_i,
    output logic [NUM_CH*DATA_W-1:0] dac_code_o,
    output logic                     shdn_o
);
    localparam int ADDR_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int FRAME_BITS = ADDR_W + RSV_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 4);

    // pin order: shdn, clear, load, sdi, sclk, cs
    logic [5:0] pins_raw, pins_s;
    logic cs_s, sclk_s, sdi_s, load_s, clr_s;
    logic sclk_d, sclk_rise;

    assign pins_raw = {shdn_i, clear_n_i, load_n_i, sdi_i, sclk_i, cs_n_i};

    dacfe_sync #(.W(6), .RST_VAL(6'b011001)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .d   (pins_raw),
        .q   (pins_s)
    );

    assign cs_s   = pins_s[0];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[2];
    assign load_s = pins_s[3];
    assign clr_s  = pins_s[4];
    assign shdn_o = pins_s[5];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end
    assign sclk_rise = sclk_s & ~sclk_d;

    frame_state_e            st;
    logic [CNT_W-1:0]        bit_cnt;
    logic [FRAME_BITS-1:0]   shreg;
    logic                    wr_en;
    logic [NUM_CH*DATA_W-1:0] in_flat;

    dacfe_frame_fsm #(.FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_s     (cs_s),
        .sclk_rise(sclk_rise),
        .sdi_s    (sdi_s),
        .st       (st),
        .bit_cnt  (bit_cnt),
        .shreg    (shreg),
        .wr_en    (wr_en)
    );

    dacfe_reg_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_s   (clr_s),
        .load_s  (load_s),
        .wr_en   (wr_en),
        .wr_addr (shreg[FRAME_BITS-1 -: ADDR_W]),
        .wr_data (shreg[DATA_W-1:0]),
        .in_flat (in_flat),
        .dac_flat(dac_code_o)
    );
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
    import dacfe_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int DATA_W     = 8,
    parameter int FRAME_BITS = 12,
    parameter int CNT_W      = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_s,
    input logic                     clr_s,
    input logic                     load_s,
    input frame_state_e             st,
    input logic [CNT_W-1:0]         bit_cnt,
    input logic [FRAME_BITS-1:0]    shreg,
    input logic                     wr_en,
    input logic [NUM_CH*DATA_W-1:0] in_flat,
    input logic [NUM_CH*DATA_W-1:0] dac_code_o
);
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> (dac_code_o == '0 && in_flat == '0)); // R6
    AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && !load_s) |=> dac_code_o == $past(in_flat)); // R4
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_s && load_s) |=> $stable(dac_code_o)); // R5
    AST_FULL_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> bit_cnt == CNT_W'(FRAME_BITS)); // R7
    AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R3
    AST_NO_SHIFT_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (st != FS_SHIFT || cs_s) |=> $stable(shreg)); // R2
endmodule

bind quad_dac_serial_front dacfe_checker #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .clr_s     (clr_s),
    .load_s    (load_s),
    .st        (st),
    .bit_cnt   (bit_cnt),
    .shreg     (shreg),
    .wr_en     (wr_en),
    .in_flat   (in_flat),
    .dac_code_o(dac_code_o)
);

// File: tb/tb_quad_dac_serial_front.sv
module tb_quad_dac_serial_front;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic load_n = 1'b1, clear_n = 1'b1, shdn = 1'b0;
    logic [31:0] dac_code_o;
    logic shdn_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_in [4];
    logic [7:0] exp_dac[4];

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_dac_serial_front dut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
        .load_n_i(load_n), .clear_n_i(clear_n), .shdn_i(shdn),
        .dac_code_o(dac_code_o), .shdn_o(shdn_o)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        for (int c = 0; c < 4; c++)
            chk($sformatf("%s ch%0d", tag, c), 32'(dac_code_o[c*8 +: 8]), 32'(exp_dac[c]));
    endtask

    function automatic void model_load();
        if (clear_n) for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
    endfunction

    function automatic void model_write(int addr, logic [7:0] data);
        if (clear_n) exp_in[addr] = data;
        if (!load_n) model_load();
    endfunction

    task automatic sclk_bit(logic b);
        sdi = b; tick(3);
        sclk = 1'b1; tick(4);
        sclk = 1'b0; tick(3);
    endtask

    task automatic shift_bits(logic [15:0] w, int hi, int lo);
        for (int i = hi; i >= lo; i--) sclk_bit(w[i]);
    endtask

    task automatic frame(int addr, logic [1:0] rsv, logic [7:0] data);
        logic [15:0] w;
        w = {4'b0, 2'(addr), rsv, data};
        cs_n = 1'b0; tick(4);
        shift_bits(w, 11, 0);
        tick(3); cs_n = 1'b1; tick(10);
        model_write(addr, data);
    endtask

    task automatic bad_frame(int nbits, logic [15:0] w);
        cs_n = 1'b0; tick(4);
        shift_bits(w, nbits - 1, 0);
        tick(3); cs_n = 1'b1; tick(10);
    endtask

    task automatic pulse_load();
        load_n = 1'b0; tick(8);
        model_load();
        load_n = 1'b1; tick(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int c = 0; c < 4; c++) begin exp_in[c] = 8'h00; exp_dac[c] = 8'h00; end
        tick(3); rst_n = 1'b1; tick(4);

        // R10 reset state
        check_all("R10 reset");
        chk("R10 shdn_o", 32'(shdn_o), 32'd0);

        // R1 address map, reserved bits ignored; R5 hold without load
        frame(0, 2'b11, 8'hA5);
        frame(1, 2'b01, 8'h3C);
        frame(2, 2'b10, 8'h81);
        frame(3, 2'b00, 8'h7E);
        check_all("R5 hold before load");
        pulse_load();
        check_all("R1 R3 after load");
        // R3 a single write leaves the other channels
        frame(2, 2'b00, 8'h42);
        pulse_load();
        check_all("R3 single channel");

        // R4 transparent while strobe low
        load_n = 1'b0; tick(6); model_load();
        frame(1, 2'b00, 8'hC3);
        check_all("R4 transparent");
        load_n = 1'b1; tick(6);

        // R7 bad counts
        bad_frame(11, 16'h0FFF);
        bad_frame(13, 16'h1FFF);
        bad_frame(1, 16'h0001);
        pulse_load();
        check_all("R7 discard");

        // R2 serial clocks with select high
        load_n = 1'b0; tick(6);
        for (int i = 0; i < 14; i++) sclk_bit(i[0]);
        tick(6);
        check_all("R2 select high");
        load_n = 1'b1; tick(6);

        // R11 load mid-frame
        frame(0, 2'b00, 8'h19);
        cs_n = 1'b0; tick(4);
        shift_bits({4'b0, 2'd3, 2'b00, 8'hE7}, 11, 6);
        pulse_load();
        check_all("R11 load mid-frame");
        shift_bits({4'b0, 2'd3, 2'b00, 8'hE7}, 5, 0);
        tick(3); cs_n = 1'b1; tick(10);
        model_write(3, 8'hE7);
        pulse_load();
        check_all("R11 frame after load");

        // R6 clear zeroes, ignores writes and loads
        clear_n = 1'b0; tick(6);
        for (int c = 0; c < 4; c++) begin exp_in[c] = 8'h00; exp_dac[c] = 8'h00; end
        check_all("R6 clear");
        frame(1, 2'b00, 8'h55);
        pulse_load();
        check_all("R6 write under clear");
        clear_n = 1'b1; tick(6);
        pulse_load();
        check_all("R6 after clear");

        // R8 clear pulse inside a frame
        cs_n = 1'b0; tick(4);
        shift_bits({4'b0, 2'd2, 2'b00, 8'h9B}, 11, 5);
        clear_n = 1'b0; tick(6); clear_n = 1'b1; tick(6);
        shift_bits({4'b0, 2'd2, 2'b00, 8'h9B}, 4, 0);
        tick(3); cs_n = 1'b1; tick(10);
        model_write(2, 8'h9B);
        pulse_load();
        check_all("R8 frame across clear");

        // R9 shutdown
        shdn = 1'b1; tick(6);
        chk("R9 shdn_o high", 32'(shdn_o), 32'd1);
        check_all("R9 contents kept");
        frame(0, 2'b00, 8'h6D);
        pulse_load();
        check_all("R9 write in shutdown");
        shdn = 1'b0; tick(6);
        chk("R9 shdn_o low", 32'(shdn_o), 32'd0);
        check_all("R9 after shutdown");

        // random mix
        for (int it = 0; it < 50; it++) begin
            int op;
            op = int'($urandom_range(0, 5));
            if (op <= 2) begin
                frame(int'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
            end else if (op == 3) begin
                int n;
                n = int'($urandom_range(1, 13));
                if (n >= 12) n++;
                bad_frame(n, 16'($urandom_range(0, 65535)));
            end else if (op == 4) begin
                pulse_load();
            end else begin
                load_n = ~load_n; tick(6);
                if (!load_n) model_load();
            end
            check_all("R3 R4 R5 R7 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule